// File: doc/BRIEF.md
# Byte ALU with Flag Register

This block is the arithmetic and logic engine of a small 8-bit controller datapath. Each accepted operation takes two data bytes, a 4-bit operation code and an incoming carry bit. It registers the result byte and a zero indication. It also updates a flag byte that holds carry, half-carry and signed overflow. The surrounding datapath normally feeds the live carry flag back into the carry input. Instruction decode, operand fetch and memory access are handled elsewhere.

The flag byte has two halves. The live flags sit in the upper half. The lower half holds a saved copy of them. A single flag-swap operation exchanges the two halves, so firmware can save or restore all flags in one step. The flag byte can also be loaded directly as a data byte. The carry flag also serves as a one-bit accumulator for moving single bits between a byte and the flag.

Top module: `alu8_psw`

## Requirements
- R1: While `rst` is high, and on the first clock after it goes low, `res_q` is 0x00, `zero_q` is 1 and `psw_q` is 0x00.
- R2: An operation presented with `op_valid` high is reflected in `res_q`, `zero_q` and `psw_q` right after the next rising edge. When `op_valid` is low, `res_q` and `zero_q` hold their values.
- R3: Flag byte layout: live carry C is bit 7, half-carry H is bit 6 and overflow OV is bit 5. The saved copies are bit 3 (C), bit 2 (H) and bit 1 (OV). Bits 4 and 0 always read 0.
- R4: Codes 0 (add) and 1 (add with carry) produce opa+opb (+carry_in for code 1). C takes the carry out of bit 7 and H takes the carry out of bit 3.
- R5: For every arithmetic code (0, 1, 2, 7, 8), OV is 1 exactly when one, but not both, of the carries out of bit 6 and bit 7 occurs.
- R6: Code 2 (subtract with carry) produces opa + ~opb + carry_in. The resulting C is 1 when no borrow occurred and 0 when a borrow occurred.
- R7: Codes 7 (increment) and 8 (decrement) produce opa+1 and opa-1. They update H and OV and leave C unchanged.
- R8: Codes 3 (AND), 4 (OR), 5 (XOR), 6 (complement opa) and 12 (swap the nibbles of opa) leave the whole flag byte unchanged.
- R9: Code 9 rotates left through carry and gives {opa[6:0], carry_in} with C=opa[7]. Code 10 rotates right and gives {carry_in, opa[7:1]} with C=opa[0]. Both leave H and OV unchanged.
- R10: Code 11 (shift left) gives {opa[6:0], 0} with C=opa[7]. The incoming carry is not fed in, and H and OV are unchanged.
- R11: Code 13 copies bit opb[2:0] of opa into C and passes opa to the result. Code 14 returns opa with bit opb[2:0] replaced by carry_in and leaves the flags unchanged.
- R12: Code 15 exchanges the upper and lower nibbles of the flag byte, and the result is the new flag byte.
- R13: When `psw_wr_en` is high, the flag byte becomes `psw_wr_data & 0xEE` after the edge. This write takes precedence over any flag change from an operation in the same cycle, while that operation's result is still registered.
- R14: `zero_q` is 1 exactly when `res_q` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation on the inputs this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| opa | input | 8 | First operand (destination byte) |
| opb | input | 8 | Second operand, or bit index in opb[2:0] for bit operations |
| carry_in | input | 1 | Incoming carry for carry-using operations |
| psw_wr_en | input | 1 | Load the flag byte from psw_wr_data |
| psw_wr_data | input | 8 | Byte to load into the flag byte |
| res_q | output | 8 | Registered result |
| zero_q | output | 1 | Registered zero indication of the result |
| psw_q | output | 8 | Flag byte |

## Verification
The assertions assume that `op_valid` and `psw_wr_en` are low while reset is applied. They also assume that the operation code and operands are stable across the edge at which they are accepted. The bench drives every input at the falling edge and holds strobes low during reset, so it stays within these assumptions. The bench checks each operation against a model built from the requirements. This model carries the expected flag byte from one operation to the next, so a flag that is wrongly changed or kept shows up in later checks too. Directed cases cover the carry out of bit 3, overflow with no carry out of bit 7, the borrow in both directions, and a flag write that collides with an operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUBC  = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_CPL   = 4'd6,
    OP_INC   = 4'd7,
    OP_DEC   = 4'd8,
    OP_RLC   = 4'd9,
    OP_RRC   = 4'd10,
    OP_SHL   = 4'd11,
    OP_NSWAP = 4'd12,
    OP_BTOC  = 4'd13,
    OP_CTOB  = 4'd14,
    OP_FSWAP = 4'd15
  } alu_op_e;

  localparam int PSW_W      = 8;
  localparam int PSW_C      = 7;
  localparam int PSW_H      = 6;
  localparam int PSW_OV     = 5;
  localparam logic [PSW_W-1:0] PSW_MASK = 8'hEE;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_half,
  output logic             c_pre,
  output logic             c_top
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH:0] cy;

  assign cy[0] = cin;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic p;
      assign p        = a[i] ^ b[i];
      assign sum[i]   = p ^ cy[i];
      assign cy[i+1]  = (a[i] & b[i]) | (p & cy[i]);
    end
  endgenerate

  assign c_half = cy[HALF];
  assign c_pre  = cy[WIDTH-1];
  assign c_top  = cy[WIDTH];
endmodule

// File: rtl/alu8_shiftlogic.sv
module alu8_shiftlogic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             new_c,
  output logic             upd_c
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam int HALF  = WIDTH / 2;

  logic [IDX_W-1:0] idx;
  assign idx = b[IDX_W-1:0];

  always_comb begin
    res   = a;
    new_c = 1'b0;
    upd_c = 1'b0;
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_CPL:   res = ~a;
      OP_RLC: begin
        res   = {a[WIDTH-2:0], cin};
        new_c = a[WIDTH-1];
        upd_c = 1'b1;
      end
      OP_RRC: begin
        res   = {cin, a[WIDTH-1:1]};
        new_c = a[0];
        upd_c = 1'b1;
      end
      OP_SHL: begin
        res   = {a[WIDTH-2:0], 1'b0};
        new_c = a[WIDTH-1];
        upd_c = 1'b1;
      end
      OP_NSWAP: res = {a[HALF-1:0], a[WIDTH-1:HALF]};
      OP_BTOC: begin
        new_c = a[idx];
        upd_c = 1'b1;
      end
      OP_CTOB:  res[idx] = cin;
      default:  res = a;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PSW_W-1:0] wr_data,
  input  logic             swap,
  input  logic             upd_c,
  input  logic             new_c,
  input  logic             upd_hov,
  input  logic             new_h,
  input  logic             new_ov,
  output logic [PSW_W-1:0] q
);
  localparam int NIB = PSW_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data & PSW_MASK;
    end else if (swap) begin
      q <= {q[NIB-1:0], q[PSW_W-1:NIB]} & PSW_MASK;
    end else begin
      if (upd_c) q[PSW_C] <= new_c;
      if (upd_hov) begin
        q[PSW_H]  <= new_h;
        q[PSW_OV] <= new_ov;
      end
    end
  end
endmodule

// File: rtl/alu8_psw.sv
module alu8_psw
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  input  logic             psw_wr_en,
  input  logic [PSW_W-1:0] psw_wr_data,
  output logic [WIDTH-1:0] res_q,
  output logic             zero_q,
  output logic [PSW_W-1:0] psw_q
);
  localparam int NIB = PSW_W / 2;

  alu_op_e          op;
  logic [WIDTH-1:0] add_b;
  logic             add_ci;
  logic             is_arith;
  logic             keep_c;
  logic [WIDTH-1:0] sum;
  logic             c_half, c_pre, c_top;
  logic [WIDTH-1:0] sl_res;
  logic             sl_c, sl_upd;
  logic [PSW_W-1:0] psw_swapped;
  logic [WIDTH-1:0] res_d;

  assign op = alu_op_e'(op_code);

  // operand conditioning for the shared adder
  always_comb begin
    add_b    = opb;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    keep_c   = 1'b0;
    unique case (op)
      OP_ADD:  begin add_b = opb;                add_ci = 1'b0;     end
      OP_ADDC: begin add_b = opb;                add_ci = carry_in; end
      OP_SUBC: begin add_b = ~opb;               add_ci = carry_in; end
      OP_INC:  begin add_b = '0;                 add_ci = 1'b1; keep_c = 1'b1; end
      OP_DEC:  begin add_b = '1;                 add_ci = 1'b0; keep_c = 1'b1; end
      default: begin is_arith = 1'b0; end
    endcase
  end

  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .a      (opa),
    .b      (add_b),
    .cin    (add_ci),
    .sum    (sum),
    .c_half (c_half),
    .c_pre  (c_pre),
    .c_top  (c_top)
  );

  alu8_shiftlogic #(.WIDTH(WIDTH)) u_shiftlogic (
    .op    (op),
    .a     (opa),
    .b     (opb),
    .cin   (carry_in),
    .res   (sl_res),
    .new_c (sl_c),
    .upd_c (sl_upd)
  );

  assign psw_swapped = {psw_q[NIB-1:0], psw_q[PSW_W-1:NIB]};

  always_comb begin
    if (is_arith)            res_d = sum;
    else if (op == OP_FSWAP) res_d = WIDTH'(psw_swapped & PSW_MASK);
    else                     res_d = sl_res;
  end

  alu8_flagreg u_flagreg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (psw_wr_en),
    .wr_data (psw_wr_data),
    .swap    (op_valid && op == OP_FSWAP),
    .upd_c   (op_valid && ((is_arith && !keep_c) || sl_upd)),
    .new_c   (is_arith ? c_top : sl_c),
    .upd_hov (op_valid && is_arith),
    .new_h   (c_half),
    .new_ov  (c_top ^ c_pre),
    .q       (psw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b1;
    end else if (op_valid) begin
      res_q  <= res_d;
      zero_q <= (res_d == '0);
    end
  end
endmodule

// File: rtl/alu8_psw_chk.sv
module alu8_psw_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] opa,
  input logic             carry_in,
  input logic             psw_wr_en,
  input logic [PSW_W-1:0] psw_wr_data,
  input logic [WIDTH-1:0] res_q,
  input logic             zero_q,
  input logic [PSW_W-1:0] psw_q
);
  logic flag_neutral;
  assign flag_neutral = op_code inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd12, 4'd14};

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (psw_q[4] == 1'b0 && psw_q[0] == 1'b0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_q) && $stable(zero_q)); // R2

  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !psw_wr_en && flag_neutral) |=> $stable(psw_q)); // R8

  AST_INCDEC_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !psw_wr_en && (op_code == 4'd7 || op_code == 4'd8))
      |=> psw_q[PSW_C] == $past(psw_q[PSW_C])); // R7

  AST_RLC_FEED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !psw_wr_en && op_code == 4'd9)
      |=> (res_q[0] == $past(carry_in)) && (psw_q[PSW_C] == $past(opa[WIDTH-1]))); // R9

  AST_SHL_NO_FEED: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd11) |=> res_q[0] == 1'b0); // R10

  AST_PSW_LOAD: assert property (@(posedge clk) disable iff (rst)
    psw_wr_en |=> psw_q == ($past(psw_wr_data) & PSW_MASK)); // R13

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_q == (res_q == '0)); // R14
endmodule

bind alu8_psw alu8_psw_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .opa         (opa),
  .carry_in    (carry_in),
  .psw_wr_en   (psw_wr_en),
  .psw_wr_data (psw_wr_data),
  .res_q       (res_q),
  .zero_q      (zero_q),
  .psw_q       (psw_q)
);

// File: tb/test_alu8_psw.sv
module test_alu8_psw;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       carry_in = 1'b0;
  logic       psw_wr_en = 1'b0;
  logic [7:0] psw_wr_data = '0;
  logic [7:0] res_q;
  logic       zero_q;
  logic [7:0] psw_q;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_psw = 8'h00;
  logic [7:0] exp_res = 8'h00;
  logic       done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu8_psw i_alu8_psw (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .carry_in(carry_in), .psw_wr_en(psw_wr_en),
    .psw_wr_data(psw_wr_data), .res_q(res_q), .zero_q(zero_q), .psw_q(psw_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model from the requirements: returns {zero, result, flags}
  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci,
                                        input logic [7:0] p);
    logic [7:0] r, np, bb;
    logic [8:0] s;
    logic [4:0] hs;
    logic [7:0] ls;
    logic cc, ar, kc;
    r = a; np = p; bb = 8'h00; cc = 1'b0; ar = 1'b0; kc = 1'b0;
    case (op)
      4'd0:  begin bb = b;     ar = 1'b1; end
      4'd1:  begin bb = b;     cc = ci; ar = 1'b1; end
      4'd2:  begin bb = ~b;    cc = ci; ar = 1'b1; end
      4'd3:  r = a & b;
      4'd4:  r = a | b;
      4'd5:  r = a ^ b;
      4'd6:  r = ~a;
      4'd7:  begin bb = 8'h01; ar = 1'b1; kc = 1'b1; end
      4'd8:  begin bb = 8'hFF; ar = 1'b1; kc = 1'b1; end
      4'd9:  begin r = {a[6:0], ci};   np[7] = a[7]; end
      4'd10: begin r = {ci, a[7:1]};   np[7] = a[0]; end
      4'd11: begin r = {a[6:0], 1'b0}; np[7] = a[7]; end
      4'd12: r = {a[3:0], a[7:4]};
      4'd13: np[7] = a[b[2:0]];
      4'd14: r[b[2:0]] = ci;
      default: begin np = {p[3:0], p[7:4]}; r = np; end
    endcase
    if (ar) begin
      s  = {1'b0, a} + {1'b0, bb} + {8'h00, cc};
      hs = {1'b0, a[3:0]} + {1'b0, bb[3:0]} + {4'h0, cc};
      ls = {1'b0, a[6:0]} + {1'b0, bb[6:0]} + {7'h00, cc};
      r  = s[7:0];
      if (!kc) np[7] = s[8];
      np[6] = hs[4];
      np[5] = ls[7] ^ s[8];
    end
    return {(r == 8'h00), r, np};
  endfunction

  task automatic do_op(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic ci);
    logic [16:0] m;
    m = model(op, a, b, ci, exp_psw);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; opa = a; opb = b; carry_in = ci;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    exp_res = m[15:8];
    exp_psw = m[7:0];
    chk(req, {23'd0, zero_q, res_q}, {23'd0, m[16], m[15:8]});
    chk(req, {24'd0, psw_q}, {24'd0, m[7:0]});
  endtask

  task automatic load_psw(input logic [7:0] d);
    @(negedge clk);
    psw_wr_en = 1'b1; psw_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    psw_wr_en = 1'b0;
    exp_psw = d & 8'hEE;
    chk("R13 load", {24'd0, psw_q}, {24'd0, d & 8'hEE});
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {15'd0, zero_q, res_q, psw_q}, {15'd0, 1'b1, 8'h00, 8'h00});
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after", {15'd0, zero_q, res_q, psw_q}, {15'd0, 1'b1, 8'h00, 8'h00});
  endtask

  task automatic t_add();
    do_op("R4 add", 4'd0, 8'h0F, 8'h01, 1'b0);
    chk("R4 H literal", {24'd0, psw_q}, 32'h40);
    do_op("R5 ov", 4'd0, 8'h7F, 8'h01, 1'b0);
    chk("R5 ov literal", {24'd0, psw_q}, 32'h60);
    do_op("R4 wrap", 4'd0, 8'hFF, 8'h01, 1'b0);
    chk("R14 zero literal", {23'd0, zero_q, psw_q}, {23'd0, 1'b1, 8'hC0});
    do_op("R5 neg ov", 4'd0, 8'h80, 8'h80, 1'b0);
    chk("R5 neg literal", {24'd0, psw_q}, 32'hA0);
    do_op("R4 addc", 4'd1, 8'h10, 8'h20, 1'b1);
    chk("R4 addc literal", {24'd0, res_q}, 32'h31);
  endtask

  task automatic t_subc();
    do_op("R6 nob", 4'd2, 8'h05, 8'h03, 1'b1);
    chk("R6 no borrow", {24'd0, res_q, psw_q} >> 0, {16'd0, 8'h02, 8'hC0});
    do_op("R6 bor", 4'd2, 8'h03, 8'h05, 1'b1);
    chk("R6 borrow", {16'd0, res_q, psw_q}, {16'd0, 8'hFE, 8'h00});
    do_op("R6 cin0", 4'd2, 8'h05, 8'h03, 1'b0);
    chk("R6 cin0 literal", {24'd0, res_q}, 32'h01);
  endtask

  task automatic t_logic();
    load_psw(8'hFF);
    do_op("R8 and", 4'd3, 8'hF0, 8'h3C, 1'b1);
    do_op("R8 or",  4'd4, 8'hF0, 8'h0C, 1'b0);
    do_op("R8 xor", 4'd5, 8'hAA, 8'hAA, 1'b1);
    do_op("R8 cpl", 4'd6, 8'h5A, 8'h00, 1'b0);
    do_op("R8 nswap", 4'd12, 8'h3C, 8'h00, 1'b0);
    chk("R8 flags kept", {24'd0, psw_q}, 32'hEE);
  endtask

  task automatic t_incdec();
    load_psw(8'h80);
    do_op("R7 inc", 4'd7, 8'hFF, 8'h00, 1'b0);
    chk("R7 C kept", {24'd0, psw_q[7], res_q}, {24'd0, 1'b1, 8'h00});
    load_psw(8'h00);
    do_op("R7 dec", 4'd8, 8'h00, 8'h00, 1'b1);
    chk("R7 dec C kept", {24'd0, psw_q[7], res_q}, {24'd0, 1'b0, 8'hFF});
    do_op("R7 inc ov", 4'd7, 8'h7F, 8'h00, 1'b0);
    do_op("R7 dec ov", 4'd8, 8'h80, 8'h00, 1'b0);
  endtask

  task automatic t_shift();
    load_psw(8'h60);
    do_op("R9 rlc", 4'd9, 8'h81, 8'h00, 1'b1);
    chk("R9 rlc literal", {16'd0, res_q, psw_q}, {16'd0, 8'h03, 8'hE0});
    do_op("R9 rrc", 4'd10, 8'h02, 8'h00, 1'b1);
    chk("R9 rrc literal", {16'd0, res_q, psw_q}, {16'd0, 8'h81, 8'h60});
    do_op("R10 shl", 4'd11, 8'hC1, 8'h00, 1'b1);
    chk("R10 shl literal", {16'd0, res_q, psw_q}, {16'd0, 8'h82, 8'hE0});
  endtask

  task automatic t_bits();
    do_op("R11 btoc0", 4'd13, 8'h10, 8'h03, 1'b1);
    chk("R11 btoc clear", {24'd0, psw_q[7], res_q}, {24'd0, 1'b0, 8'h10});
    do_op("R11 btoc1", 4'd13, 8'h10, 8'h04, 1'b0);
    do_op("R11 ctob", 4'd14, 8'h00, 8'h07, 1'b1);
    chk("R11 ctob literal", {24'd0, res_q}, 32'h80);
    do_op("R11 ctob clr", 4'd14, 8'hFF, 8'h02, 1'b0);
  endtask

  task automatic t_psw();
    load_psw(8'hFF);
    chk("R3 reserved", {24'd0, psw_q}, 32'hEE);
    load_psw(8'hA0);
    do_op("R12 save", 4'd15, 8'h00, 8'h00, 1'b0);
    chk("R12 swapped", {16'd0, res_q, psw_q}, {16'd0, 8'h0A, 8'h0A});
    do_op("R12 new", 4'd0, 8'h40, 8'h40, 1'b0);
    do_op("R12 restore", 4'd15, 8'h00, 8'h00, 1'b0);
    chk("R12 restored", {24'd0, psw_q}, 32'hA2);
    // collision: write wins over flags, result still registered
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd0; opa = 8'hFF; opb = 8'h01; carry_in = 1'b0;
    psw_wr_en = 1'b1; psw_wr_data = 8'h24;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; psw_wr_en = 1'b0;
    exp_psw = 8'h24;
    chk("R13 collide psw", {24'd0, psw_q}, 32'h24);
    chk("R13 collide res", {23'd0, zero_q, res_q}, {23'd0, 1'b1, 8'h00});
  endtask

  task automatic t_idle();
    do_op("R2 set", 4'd0, 8'h12, 8'h22, 1'b0);
    @(negedge clk);
    opa = 8'h99; opb = 8'h11; op_code = 4'd6;
    repeat (3) @(negedge clk);
    chk("R2 hold", {15'd0, zero_q, res_q, psw_q}, {15'd0, 1'b0, 8'h34, exp_psw});
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] a, b;
        a = 8'(k * 8'h37 + op * 8'h1D);
        b = 8'(k * 8'h59 + 8'h0B);
        do_op("R2 sweep", 4'(op), a, b, 1'(k));
      end
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_subc();
    t_logic();
    t_incdec();
    t_shift();
    t_bits();
    t_psw();
    t_idle();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule